// File: doc/BRIEF.md
# Floating-Point Unordered Compare Unit

This unit decodes and executes the floating-point set-flag compares whose result is true when the operands cannot be ordered. It handles six predicates: unordered, equal-or-unordered, less-or-unordered, less-equal-or-unordered, greater-or-unordered and greater-equal-or-unordered. Each predicate works in single precision, where the operand is one 32-bit register, or in double precision, where the operand is a 64-bit value formed from a register and its partner register.

All six predicates come from one quiet relation that takes one of four values: less, equal, greater or unordered. The two greater-type predicates reuse the less-type evaluation with the operands exchanged. The pipeline stage in front of the unit passes in the instruction word, the register values it has already read and two configuration inputs: a version word and a single-precision enable. One cycle later the unit returns the compare flag and a write strobe for it. It returns an illegal-instruction pulse instead when the instruction is not one of its encodings or fails a legality check. An invalid-operation flag accompanies the strobe when a signaling NaN was compared.

Top module: `fp_ucmp_unit`

## Requirements
- R1: An instruction is accepted only when bits [31:26] are 6'b110010 and bits [7:0] hold one of the codes 0x28, 0x2A, 0x2B, 0x2C, 0x2D, 0x2E (single precision) or the same codes with bit 4 set, 0x38 to 0x3E (double precision). A double-precision code also needs bits [25:21] and bit 10 to be zero. Any other word presented with valid asserted produces the illegal pulse.
- R2: Code nibble 0xE (un) sets the flag exactly when at least one operand is a NaN, where a NaN has an exponent field of all ones and a nonzero mantissa.
- R3: Code nibble 0x8 (ueq) sets the flag when the operands are equal or unordered.
- R4: Code nibble 0xC (ult) sets the flag when a < b or the operands are unordered. Code nibble 0xD (ule) sets the flag unless a > b.
- R5: Code nibble 0xA (ugt) gives the result of ult with a and b exchanged. Code nibble 0xB (uge) gives the result of ule with a and b exchanged.
- R6: Positive zero and negative zero compare equal. Non-NaN values are ordered by sign first and then by magnitude, and the magnitude order is reversed when both operands are negative.
- R7: A single-precision compare is illegal unless the version input is at least 0x01030000 and the single-precision enable is 1. These two inputs have no effect on double-precision compares.
- R8: In double precision, register a is field [20:16] and register b is field [15:11]. Their stride bits are bit 9 and bit 8. The compare is illegal if the register number plus 1 plus the stride is 32 or more for either operand. The register value forms bits [63:32] of the operand and the partner value forms bits [31:0].
- R9: The invalid flag rises with the write strobe when either operand of a legal compare is a signaling NaN (top mantissa bit clear). Quiet NaNs do not raise it.
- R10: The flag, strobe, illegal and invalid outputs are registered and appear in the cycle after valid. Each is a one-cycle pulse except the flag, which holds. An illegal instruction raises only the illegal pulse and leaves the flag unchanged.
- R11: After reset all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction and operands are presented this cycle |
| insn_i | input | 32 | Instruction word |
| opa_r_i | input | 32 | Value of register a (single operand, or upper half of double) |
| opa_p_i | input | 32 | Value of the partner of register a (lower half of double) |
| opb_r_i | input | 32 | Value of register b (single operand, or upper half of double) |
| opb_p_i | input | 32 | Value of the partner of register b (lower half of double) |
| ver_i | input | 32 | Architecture version word |
| sp_en_i | input | 1 | Single-precision support enabled |
| flag_o | output | 1 | Compare flag, held until the next legal compare |
| flag_we_o | output | 1 | One-cycle strobe: flag_o was written |
| illegal_o | output | 1 | One-cycle illegal-instruction indication |
| invalid_o | output | 1 | One-cycle invalid-operation exception flag |

## Verification
The only internal state is the output register stage, so each fault in the decode or relation logic shows up in the cycle after the instruction, as a wrong flag, strobe, illegal or invalid value. A swap applied to the wrong code would flip the result only for ordered operand pairs that differ, so every predicate is run over a grid of ordered, equal, signed-zero and NaN pairs in both precisions. A stale flag after an illegal instruction is found by the idle cycles that follow, because they expect the flag value written by the last legal compare.

// File: rtl/fucmp_pkg.sv
package fucmp_pkg;

    localparam int INSN_W     = 32;
    localparam int XLEN       = 32;
    localparam int NREG       = 32;
    localparam int REGIDX_W   = $clog2(NREG);

    // Instruction field positions
    localparam int OPC_LSB    = 26;
    localparam int OPC_W      = 6;
    localparam int HIZ_LSB    = 21;
    localparam int RA_LSB     = 16;
    localparam int RB_LSB     = 11;
    localparam int PAD_BIT    = 10;
    localparam int PA_BIT     = 9;
    localparam int PB_BIT     = 8;
    localparam int FN_W       = 8;

    localparam logic [OPC_W-1:0] MAJOR_FP = 6'b110010;
    localparam logic [XLEN-1:0]  VER_MIN  = 32'h0103_0000;

    // Floating-point formats
    localparam int SP_EXP = 8;
    localparam int SP_MAN = 23;
    localparam int DP_EXP = 11;
    localparam int DP_MAN = 52;

    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic [1:0] {
        PRED_UEQ = 2'd0,
        PRED_ULT = 2'd1,
        PRED_ULE = 2'd2,
        PRED_UN  = 2'd3
    } pred_e;

    typedef struct packed {
        logic  hit;
        logic  legal;
        logic  dbl;
        logic  swap;
        pred_e pred;
    } dec_t;

    typedef struct packed {
        logic sign;
        logic zero;
        logic nan;
        logic snan;
    } fcls_t;

    function automatic logic pair_ok(logic [REGIDX_W-1:0] r, logic p);
        logic [REGIDX_W:0] top;
        top = {1'b0, r} + (REGIDX_W+1)'(1) + {{REGIDX_W{1'b0}}, p};
        return top < (REGIDX_W+1)'(NREG);
    endfunction

    function automatic logic pred_eval(pred_e p, rel_e r);
        logic res;
        case (p)
            PRED_UEQ: res = (r == REL_EQ) || (r == REL_UN);
            PRED_ULT: res = (r == REL_LT) || (r == REL_UN);
            PRED_ULE: res = (r != REL_GT);
            default:  res = (r == REL_UN);
        endcase
        return res;
    endfunction

endpackage

// File: rtl/fucmp_decode.sv
module fucmp_decode
    import fucmp_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    input  logic [XLEN-1:0]   ver_i,
    input  logic              sp_en_i,
    output dec_t              dec_o
);

    logic [FN_W-1:0] fn;
    logic            major_ok;
    logic            fam_ok;
    logic            nib_ok;
    logic            fmt_ok;
    logic            sp_ok;
    logic            dp_ok;
    logic            swap;
    pred_e           pred;

    always_comb begin
        fn       = insn_i[FN_W-1:0];
        major_ok = (insn_i[OPC_LSB +: OPC_W] == MAJOR_FP);
        fam_ok   = (fn[7:5] == 3'b001);
        nib_ok   = 1'b1;
        swap     = 1'b0;
        pred     = PRED_UN;
        case (fn[3:0])
            4'h8: pred = PRED_UEQ;
            4'hA: begin pred = PRED_ULT; swap = 1'b1; end
            4'hB: begin pred = PRED_ULE; swap = 1'b1; end
            4'hC: pred = PRED_ULT;
            4'hD: pred = PRED_ULE;
            4'hE: pred = PRED_UN;
            default: nib_ok = 1'b0;
        endcase
        fmt_ok = !fn[4] ||
                 ((insn_i[HIZ_LSB +: REGIDX_W] == '0) && !insn_i[PAD_BIT]);
        sp_ok  = (ver_i >= VER_MIN) && sp_en_i;
        dp_ok  = pair_ok(insn_i[RA_LSB +: REGIDX_W], insn_i[PA_BIT]) &&
                 pair_ok(insn_i[RB_LSB +: REGIDX_W], insn_i[PB_BIT]);

        dec_o.hit   = major_ok && fam_ok && nib_ok && fmt_ok;
        dec_o.dbl   = fn[4];
        dec_o.swap  = swap;
        dec_o.pred  = pred;
        dec_o.legal = dec_o.hit && (fn[4] ? dp_ok : sp_ok);
    end

endmodule

// File: rtl/fucmp_classify.sv
module fucmp_classify
    import fucmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] val_i,
    output fcls_t        cls_o
);

    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] man;

    always_comb begin
        expo        = val_i[MAN_W +: EXP_W];
        man         = val_i[MAN_W-1:0];
        cls_o.sign  = val_i[W-1];
        cls_o.zero  = (expo == '0) && (man == '0);
        cls_o.nan   = (&expo) && (|man);
        cls_o.snan  = cls_o.nan && !man[MAN_W-1];
    end

endmodule

// File: rtl/fucmp_relate.sv
module fucmp_relate
    import fucmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  fcls_t        cx_i,
    input  fcls_t        cy_i,
    output rel_e         rel_o
);

    logic [W-2:0] mx;
    logic [W-2:0] my;
    logic         mag_lt;
    logic         mag_eq;

    always_comb begin
        mx     = x_i[W-2:0];
        my     = y_i[W-2:0];
        mag_lt = (mx < my);
        mag_eq = (mx == my);
        if (cx_i.nan || cy_i.nan) begin
            rel_o = REL_UN;
        end else if (cx_i.zero && cy_i.zero) begin
            rel_o = REL_EQ;
        end else if (cx_i.sign != cy_i.sign) begin
            rel_o = cx_i.sign ? REL_LT : REL_GT;
        end else if (mag_eq) begin
            rel_o = REL_EQ;
        end else if (cx_i.sign) begin
            rel_o = mag_lt ? REL_GT : REL_LT;
        end else begin
            rel_o = mag_lt ? REL_LT : REL_GT;
        end
    end

endmodule

// File: rtl/fp_ucmp_unit.sv
module fp_ucmp_unit
    import fucmp_pkg::*;
#(
    parameter int RW = XLEN,
    localparam int DW = 2 * RW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [31:0]   insn_i,
    input  logic [RW-1:0] opa_r_i,
    input  logic [RW-1:0] opa_p_i,
    input  logic [RW-1:0] opb_r_i,
    input  logic [RW-1:0] opb_p_i,
    input  logic [31:0]   ver_i,
    input  logic          sp_en_i,
    output logic          flag_o,
    output logic          flag_we_o,
    output logic          illegal_o,
    output logic          invalid_o
);

    dec_t dec;

    fucmp_decode u_dec (
        .insn_i  (insn_i),
        .ver_i   (ver_i),
        .sp_en_i (sp_en_i),
        .dec_o   (dec)
    );

    // Operand steering: the swap turns ult/ule into ugt/uge
    logic [RW-1:0] x_sp, y_sp;
    logic [DW-1:0] x_dp, y_dp;

    always_comb begin
        x_sp = dec.swap ? opb_r_i : opa_r_i;
        y_sp = dec.swap ? opa_r_i : opb_r_i;
        x_dp = dec.swap ? {opb_r_i, opb_p_i} : {opa_r_i, opa_p_i};
        y_dp = dec.swap ? {opa_r_i, opa_p_i} : {opb_r_i, opb_p_i};
    end

    fcls_t cx_sp, cy_sp, cx_dp, cy_dp;
    rel_e  rel_sp, rel_dp;

    fucmp_classify #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_cls_xs (.val_i(x_sp), .cls_o(cx_sp));
    fucmp_classify #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_cls_ys (.val_i(y_sp), .cls_o(cy_sp));
    fucmp_classify #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_cls_xd (.val_i(x_dp), .cls_o(cx_dp));
    fucmp_classify #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_cls_yd (.val_i(y_dp), .cls_o(cy_dp));

    fucmp_relate #(.W(RW)) u_rel_s (
        .x_i(x_sp), .y_i(y_sp), .cx_i(cx_sp), .cy_i(cy_sp), .rel_o(rel_sp)
    );
    fucmp_relate #(.W(DW)) u_rel_d (
        .x_i(x_dp), .y_i(y_dp), .cx_i(cx_dp), .cy_i(cy_dp), .rel_o(rel_dp)
    );

    rel_e rel;
    logic snan_any;
    logic flag_next;

    always_comb begin
        rel       = dec.dbl ? rel_dp : rel_sp;
        snan_any  = dec.dbl ? (cx_dp.snan || cy_dp.snan)
                            : (cx_sp.snan || cy_sp.snan);
        flag_next = pred_eval(dec.pred, rel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o    <= 1'b0;
            flag_we_o <= 1'b0;
            illegal_o <= 1'b0;
            invalid_o <= 1'b0;
        end else if (valid_i && dec.legal) begin
            flag_o    <= flag_next;
            flag_we_o <= 1'b1;
            illegal_o <= 1'b0;
            invalid_o <= snan_any;
        end else begin
            flag_we_o <= 1'b0;
            illegal_o <= valid_i;
            invalid_o <= 1'b0;
        end
    end

    AST_WE_ILL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(flag_we_o && illegal_o)); // R10

    AST_ILL_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $stable(flag_o)); // R10

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (flag_we_o ^ illegal_o)); // R10

    AST_INV_WITH_WE: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> flag_we_o); // R9

    AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (rst)
        (cx_dp.nan || cy_dp.nan) |-> (rel_dp == REL_UN)); // R2

    AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (rst)
        (cx_sp.zero && cy_sp.zero) |-> (rel_sp == REL_EQ)); // R6

    AST_SP_VER_GATE: assert property (@(posedge clk) disable iff (rst)
        (valid_i && dec.hit && !dec.dbl && (ver_i < VER_MIN)) |=> illegal_o); // R7

endmodule

// File: tb/fp_ucmp_unit_tb.sv
module fp_ucmp_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [31:0] opa_r_i = '0, opa_p_i = '0, opb_r_i = '0, opb_p_i = '0;
    logic [31:0] ver_i = 32'h0103_0000;
    logic        sp_en_i = 1'b1;
    logic        flag_o, flag_we_o, illegal_o, invalid_o;

    always #5 clk = ~clk;

    fp_ucmp_unit dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i),
        .opa_r_i(opa_r_i), .opa_p_i(opa_p_i), .opb_r_i(opb_r_i), .opb_p_i(opb_p_i),
        .ver_i(ver_i), .sp_en_i(sp_en_i),
        .flag_o(flag_o), .flag_we_o(flag_we_o), .illegal_o(illegal_o), .invalid_o(invalid_o)
    );

    typedef struct packed {
        logic flag;
        logic we;
        logic ill;
        logic inv;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    logic  model_flag = 1'b0;
    bit    done = 1'b0;

    // ---------------- reference model ----------------
    function automatic logic is_nan64(logic [63:0] v);
        return (&v[62:52]) && (|v[51:0]);
    endfunction
    function automatic logic is_snan64(logic [63:0] v);
        return is_nan64(v) && !v[51];
    endfunction
    function automatic logic is_nan32(logic [31:0] v);
        return (&v[30:23]) && (|v[22:0]);
    endfunction
    function automatic logic is_snan32(logic [31:0] v);
        return is_nan32(v) && !v[22];
    endfunction
    // widen a non-NaN single (no subnormals) to double bits
    function automatic logic [63:0] widen(logic [31:0] v);
        logic [10:0] e;
        if (v[30:23] == 8'd0) return {v[31], 63'd0};
        if (v[30:23] == 8'hFF) e = 11'h7FF;
        else e = 11'(v[30:23]) - 11'd127 + 11'd1023;
        return {v[31], e, v[22:0], 29'd0};
    endfunction

    // flag from code nibble and operand doubles; nan = either operand NaN
    function automatic logic ref_flag(logic [3:0] nib, logic [63:0] a, logic [63:0] b, logic nan);
        real ra, rb, t;
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        if (nib == 4'hA || nib == 4'hB) begin t = ra; ra = rb; rb = t; end
        case (nib)
            4'h8: return nan || (ra == rb);
            4'hA, 4'hC: return nan || (ra < rb);
            4'hB, 4'hD: return nan || !(ra > rb);
            default: return nan;
        endcase
    endfunction

    function automatic logic [31:0] mk_s(logic [7:0] fn, logic [4:0] ra, logic [4:0] rb);
        return {6'b110010, 5'd0, ra, rb, 3'b000, fn};
    endfunction
    function automatic logic [31:0] mk_d(logic [7:0] fn, logic [4:0] ra, logic [4:0] rb,
                                         logic pa, logic pb);
        return {6'b110010, 5'd0, ra, rb, 1'b0, pa, pb, fn};
    endfunction

    // ---------------- driver ----------------
    task automatic issue(logic [31:0] insn, logic [63:0] a, logic [63:0] b,
                         logic [31:0] ver, logic spen, string tag);
        exp_t e;
        logic [7:0] fn;
        logic dbl, hit, legal, nan, snan;
        int ra, rb;
        fn  = insn[7:0];
        dbl = fn[4];
        hit = (insn[31:26] == 6'b110010) && (fn[7:5] == 3'b001) &&
              (fn[3:0] inside {4'h8, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE}) &&
              (!dbl || (insn[25:21] == 5'd0 && !insn[10]));
        ra  = int'(insn[20:16]) + 1 + int'(insn[9]);
        rb  = int'(insn[15:11]) + 1 + int'(insn[8]);
        legal = hit && (dbl ? (ra < 32 && rb < 32) : (ver >= 32'h0103_0000 && spen));
        if (dbl) begin
            nan  = is_nan64(a) || is_nan64(b);
            snan = is_snan64(a) || is_snan64(b);
        end else begin
            nan  = is_nan32(a[63:32]) || is_nan32(b[63:32]);
            snan = is_snan32(a[63:32]) || is_snan32(b[63:32]);
        end
        @(negedge clk);
        valid_i = 1'b1;
        insn_i  = insn;
        opa_r_i = a[63:32]; opa_p_i = a[31:0];
        opb_r_i = b[63:32]; opb_p_i = b[31:0];
        ver_i   = ver;
        sp_en_i = spen;
        if (legal) begin
            model_flag = dbl ? ref_flag(fn[3:0], a, b, nan)
                             : ref_flag(fn[3:0], widen(a[63:32]), widen(b[63:32]), nan);
            e = '{flag: model_flag, we: 1'b1, ill: 1'b0, inv: snan};
        end else begin
            e = '{flag: model_flag, we: 1'b0, ill: 1'b1, inv: 1'b0};
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_i = 1'b0;
            insn_i  = 32'hFFFF_FFFF;
            exp_q.push_back('{flag: model_flag, we: 1'b0, ill: 1'b0, inv: 1'b0});
            tag_q.push_back("R10 idle");
        end
    endtask

    // ---------------- monitor ----------------
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t  e;
            exp_t  got;
            string t;
            e   = exp_q.pop_front();
            t   = tag_q.pop_front();
            got = '{flag: flag_o, we: flag_we_o, ill: illegal_o, inv: invalid_o};
            n_checks++;
            if (got !== e) begin
                n_fail++;
                $display("FAIL %s: got flag/we/ill/inv=%b expected %b", t, got, e);
            end
        end
    end

    // ---------------- stimulus ----------------
    localparam int NS = 9;
    localparam int ND = 7;
    logic [31:0] sv[NS] = '{32'h3F80_0000, 32'h4000_0000, 32'hBF80_0000, 32'hC000_0000,
                            32'h0000_0000, 32'h8000_0000, 32'h7FC0_0000, 32'h7F80_0001,
                            32'h7F80_0000};
    logic [63:0] dv[ND] = '{64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000,
                            64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000,
                            64'h8000_0000_0000_0000, 64'h7FF8_0000_0000_0000,
                            64'h7FF0_0000_0000_0001};
    logic [7:0]  codes[6] = '{8'h28, 8'h2A, 8'h2B, 8'h2C, 8'h2D, 8'h2E};
    string       names[6] = '{"R3 ueq", "R5 ugt", "R5 uge", "R4 ult", "R4 ule", "R2 un"};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if ({flag_o, flag_we_o, illegal_o, invalid_o} !== 4'b0000) begin
            n_fail++;
            $display("FAIL R11 reset: got %b expected 0000",
                     {flag_o, flag_we_o, illegal_o, invalid_o});
        end

        // single precision grid; partner halves carry junk (R1/R6/R9 covered)
        for (int c = 0; c < 6; c++)
            for (int i = 0; i < NS; i++)
                for (int j = 0; j < NS; j++)
                    issue(mk_s(codes[c], 5'd3, 5'd4), {sv[i], 32'hDEAD_BEEF},
                          {sv[j], 32'h1234_5678}, 32'h0103_0000, 1'b1,
                          $sformatf("%s sp R6 R9 %0d,%0d", names[c], i, j));
        idle(2);

        // double precision grid, R8 operand layout
        for (int c = 0; c < 6; c++)
            for (int i = 0; i < ND; i++)
                for (int j = 0; j < ND; j++)
                    issue(mk_d(codes[c] | 8'h10, 5'd6, 5'd10, 1'b1, 1'b0), dv[i], dv[j],
                          32'h0, 1'b0, $sformatf("%s dp R8 R7 %0d,%0d", names[c], i, j));
        idle(2);

        // low mantissa bit decides order in double (R8 partner half)
        issue(mk_d(8'h3C, 5'd2, 5'd4, 1'b0, 1'b0), 64'h3FF0_0000_0000_0001,
              64'h3FF0_0000_0000_0002, 32'h0, 1'b0, "R8 low half order");
        issue(mk_d(8'h3C, 5'd2, 5'd4, 1'b0, 1'b0), 64'h3FF0_0000_0000_0002,
              64'h3FF0_0000_0000_0001, 32'h0, 1'b0, "R8 low half order rev");

        // R7 single-precision gating, then flag must hold
        issue(mk_s(8'h2E, 5'd1, 5'd2), {32'h7FC0_0000, 32'h0}, {32'h3F80_0000, 32'h0},
              32'h0103_0000, 1'b1, "R2 set flag");
        issue(mk_s(8'h2C, 5'd1, 5'd2), {32'h4000_0000, 32'h0}, {32'h3F80_0000, 32'h0},
              32'h0102_FFFF, 1'b1, "R7 low version");
        idle(1);
        issue(mk_s(8'h2C, 5'd1, 5'd2), {32'h4000_0000, 32'h0}, {32'h3F80_0000, 32'h0},
              32'h0103_0000, 1'b0, "R7 sp disabled");
        issue(mk_s(8'h2C, 5'd1, 5'd2), {32'h4000_0000, 32'h0}, {32'h3F80_0000, 32'h0},
              32'h0104_0000, 1'b1, "R7 newer version");

        // R8 pair bounds
        issue(mk_d(8'h38, 5'd30, 5'd2, 1'b0, 1'b0), dv[0], dv[0], 32'h0, 1'b0, "R8 a=30 p=0 ok");
        issue(mk_d(8'h38, 5'd30, 5'd2, 1'b1, 1'b0), dv[0], dv[0], 32'h0, 1'b0, "R8 a=30 p=1 illegal");
        issue(mk_d(8'h38, 5'd31, 5'd2, 1'b0, 1'b0), dv[0], dv[0], 32'h0, 1'b0, "R8 a=31 illegal");
        issue(mk_d(8'h38, 5'd2, 5'd31, 1'b0, 1'b0), dv[0], dv[0], 32'h0, 1'b0, "R8 b=31 illegal");
        issue(mk_d(8'h38, 5'd2, 5'd30, 1'b0, 1'b1), dv[0], dv[0], 32'h0, 1'b0, "R8 b=30 p=1 illegal");

        // R1 encoding rejects
        issue(mk_d(8'h38, 5'd2, 5'd4, 1'b0, 1'b0) | 32'h0020_0000, dv[0], dv[1],
              32'h0, 1'b0, "R1 dp nonzero [25:21]");
        issue(mk_d(8'h38, 5'd2, 5'd4, 1'b0, 1'b0) | 32'h0000_0400, dv[0], dv[1],
              32'h0, 1'b0, "R1 dp bit10 set");
        issue(mk_s(8'h29, 5'd1, 5'd2), {sv[0], 32'h0}, {sv[1], 32'h0},
              32'h0103_0000, 1'b1, "R1 code 0x29");
        issue(mk_s(8'h0C, 5'd1, 5'd2), {sv[0], 32'h0}, {sv[1], 32'h0},
              32'h0103_0000, 1'b1, "R1 ordered code");
        issue(mk_s(8'h2C, 5'd1, 5'd2) ^ 32'h0400_0000, {sv[0], 32'h0}, {sv[1], 32'h0},
              32'h0103_0000, 1'b1, "R1 wrong major");
        issue(mk_s(8'h2C, 5'd1, 5'd2) | 32'h03E0_0700, {sv[0], 32'h0}, {sv[1], 32'h0},
              32'h0103_0000, 1'b1, "R1 sp ignores [25:21] and [10:8]");
        idle(3);

        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule